// File: doc/BRIEF.md
# Ten-bit own-address matcher

This block sits behind the byte receiver of a two-wire serial bus target. After each start or repeated start it compares the incoming address bytes with a programmed 10-bit own address. The first byte carries the 11110 prefix, the two high address bits and the read/write bit. The second byte carries the eight low address bits.

Each byte that matches is acknowledged automatically. The acknowledge level comes from a software-set bit, so software can choose to answer with a NACK. When both bytes match, the block sets a sticky match flag and emits a one-cycle pulse that tells the surrounding controller to leave master mode. It raises an interrupt request while the flag is set and interrupts are enabled. A byte that does not match makes the block deaf until the next start.

Top module: `tenbit_addr_match`

## Requirements
- R1: The address register resets to 0x0000. A write keeps bits 9:0 as the own address, and read-back returns zero in bits 15:10.
- R2: After a start, a first byte with bits 7:3 = 11110 and bits 2:1 equal to address bits 9:8 is acknowledged. Bit 0 (read/write) plays no part in the comparison. The acknowledge is a one-cycle `ack_vld` in the cycle after `byte_vld`, with `ack_out` equal to `ack_val`.
- R3: A second byte equal to address bits 7:0, following an accepted first byte, is acknowledged in the same way. In that same cycle `match_flag` becomes 1 and `mst_clr` pulses for exactly one cycle.
- R4: A first or second byte that mismatches gets no acknowledge. All later bytes are ignored until the next start.
- R5: While `en` is 0, bytes produce no acknowledge, no flag and no `mst_clr`.
- R6: `irq` is high exactly while `match_flag` and `irq_en` are both 1.
- R7: `match_flag` stays set until `flag_clr` is asserted. A new match in the same cycle as a clear takes priority and leaves the flag set.
- R8: A start that arrives partway through the sequence restarts matching from the first byte.
- R9: `ack_vld` and `mst_clr` never fire except one cycle after a byte strobe, and `mst_clr` never fires without `ack_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | Start or repeated start seen on the bus |
| byte_vld | input | 1 | Strobe: one received address byte in `byte_in` |
| byte_in | input | 8 | Received address byte |
| en | input | 1 | Module enable |
| ack_val | input | 1 | Level driven as the acknowledge on a match |
| irq_en | input | 1 | Match interrupt enable |
| reg_we | input | 1 | Address register write strobe |
| reg_wdata | input | 16 | Address register write data |
| flag_clr | input | 1 | Software clear of the match flag |
| reg_rdata | output | 16 | Address register read-back |
| ack_out | output | 1 | Acknowledge level to drive |
| ack_vld | output | 1 | Acknowledge drive strobe |
| match_flag | output | 1 | Sticky full-address match flag |
| mst_clr | output | 1 | One-cycle pulse clearing master mode |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check several properties on every cycle:
- acknowledges and master-clear pulses only follow a byte strobe;
- a master-clear pulse always comes with an acknowledge and a set flag;
- the flag stays set until cleared;
- nothing is acknowledged while the block is disabled;
- the interrupt never fires without the flag.

The bench scenarios are needed for the rest:
- whether the comparison itself is right;
- that the read/write bit is ignored;
- that the block stays deaf after a mismatch;
- that a repeated start restarts the sequence;
- the reserved read-back bits.

// File: rtl/tenbit_addr_match.sv
module tenbit_addr_match #(
  parameter int AW = 10,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          en,
  input  logic          ack_val,
  input  logic          irq_en,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_wdata,
  input  logic          flag_clr,
  output logic [RW-1:0] reg_rdata,
  output logic          ack_out,
  output logic          ack_vld,
  output logic          match_flag,
  output logic          mst_clr,
  output logic          irq
);
  typedef enum logic [1:0] {S_DEAF, S_HI, S_LO} st_t;

  st_t          st;
  logic [AW-1:0] own;
  logic          hi_ok, lo_ok, hit_hi, hit_lo;

  assign hi_ok  = byte_in[7:3] == 5'b11110 && byte_in[2:1] == own[AW-1:AW-2];
  assign lo_ok  = byte_in == own[7:0];
  assign hit_hi = byte_vld && en && st == S_HI && hi_ok;
  assign hit_lo = byte_vld && en && st == S_LO && lo_ok;

  assign reg_rdata = {{(RW-AW){1'b0}}, own};
  assign irq       = match_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own <= '0;
    else if (reg_we) own <= reg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_DEAF;
    else if (start_det) st <= S_HI;
    else if (byte_vld) st <= hit_hi ? S_LO : S_DEAF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld    <= 1'b0;
      ack_out    <= 1'b0;
      mst_clr    <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      ack_vld <= !start_det && (hit_hi || hit_lo);
      ack_out <= (!start_det && (hit_hi || hit_lo)) ? ack_val : 1'b0;
      mst_clr <= !start_det && hit_lo;
      if (!start_det && hit_lo) match_flag <= 1'b1;
      else if (flag_clr) match_flag <= 1'b0;
    end
  end

  a_r9_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(byte_vld));
  a_r9_clr_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mst_clr |-> ack_vld);
  a_r3_clr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mst_clr |-> match_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag);
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ack_vld);
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> match_flag);
endmodule

// File: tb/tenbit_addr_match_tb.sv
module tenbit_addr_match_tb;
  logic clk = 0, rst_n = 0;
  logic start_det = 0, byte_vld = 0, en = 0, ack_val = 0, irq_en = 0;
  logic reg_we = 0, flag_clr = 0;
  logic [7:0] byte_in = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic ack_out, ack_vld, match_flag, mst_clr, irq;
  int total = 0, bad = 0;
  logic [1:0] expq[$];

  always #2.5 clk = ~clk;

  tenbit_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
    .byte_in(byte_in), .en(en), .ack_val(ack_val), .irq_en(irq_en),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .flag_clr(flag_clr),
    .reg_rdata(reg_rdata), .ack_out(ack_out), .ack_vld(ack_vld),
    .match_flag(match_flag), .mst_clr(mst_clr), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mst_clr && !ack_vld) chk(0, "R9 mst_clr without ack", 1, 0);
    if (ack_vld) begin
      if (expq.size() == 0) chk(0, "R4/R5/R9 unexpected ack", 1, 0);
      else begin
        logic [1:0] e;
        e = expq.pop_front();
        chk(ack_out == e[1], "R2/R3 ack level", ack_out, e[1]);
        chk(mst_clr == e[0], "R3 mst_clr pulse", mst_clr, e[0]);
      end
    end
  end

  task automatic start();
    @(negedge clk); start_det = 1;
    @(negedge clk); start_det = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit acked, input bit full);
    @(negedge clk); byte_vld = 1; byte_in = b;
    if (acked) expq.push_back({ack_val, full});
    @(negedge clk); byte_vld = 0;
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata == 16'h0 && !ack_vld && !match_flag && !mst_clr && !irq,
        "R1 reset state", reg_rdata, 0);
    rst_n = 1;
    @(negedge clk); reg_we = 1; reg_wdata = 16'hFEA5;
    @(negedge clk); reg_we = 0;
    chk(reg_rdata == 16'h02A5, "R1 reserved bits zero", reg_rdata, 16'h02A5);

    en = 1; ack_val = 0;
    start(); send(8'hF4, 1, 0); send(8'hA5, 1, 1);
    chk(match_flag, "R3 flag set", match_flag, 1);
    chk(!irq, "R6 irq masked", irq, 0);
    irq_en = 1; #1;
    chk(irq, "R6 irq enabled", irq, 1);
    repeat (5) @(negedge clk);
    chk(match_flag, "R7 flag sticky", match_flag, 1);
    clr();
    chk(!match_flag && !irq, "R7 flag cleared", match_flag, 0);

    ack_val = 1;
    start(); send(8'hF5, 1, 0); send(8'hA4, 0, 0); send(8'hA5, 0, 0);
    chk(!match_flag, "R4 second byte mismatch", match_flag, 0);
    start(); send(8'hF0, 0, 0); send(8'hF4, 0, 0); send(8'hA5, 0, 0);
    chk(!match_flag, "R4 first byte mismatch", match_flag, 0);

    start(); send(8'hF4, 1, 0); start(); send(8'hA5, 0, 0);
    chk(!match_flag, "R8 restart wants first byte", match_flag, 0);
    start(); send(8'hF4, 1, 0); start(); send(8'hF4, 1, 0); send(8'hA5, 1, 1);
    chk(match_flag, "R8 restart then match", match_flag, 1);
    clr();

    en = 0;
    start(); send(8'hF4, 0, 0); send(8'hA5, 0, 0);
    chk(!match_flag, "R5 disabled no match", match_flag, 0);
    en = 1;

    @(negedge clk); reg_we = 1; reg_wdata = 16'h0133;
    @(negedge clk); reg_we = 0;
    chk(reg_rdata == 16'h0133, "R1 write", reg_rdata, 16'h0133);
    start(); send(8'hF2, 1, 0); send(8'h33, 1, 1);
    chk(match_flag, "R2 other address", match_flag, 1);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R9 all acks seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule